// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block controls how a clock generator enters and leaves its low-power state. An active-low request arrives asynchronously. After it is synchronized, every clock output group is parked low. A group's enable changes only while that group's clock is in its low phase, so an output stops at a falling edge and never produces a shortened pulse. Only once every group is parked does the block turn off the VCO, and it turns off the crystal oscillator one cycle later.

When the request is released, the block restarts in the opposite order. The crystal is enabled first. The VCO follows after a settling count, and the block returns to the running phase after a second count. The output groups then re-enable on their next low phase. The total restart time is fixed by parameters and is checked at elaboration against a wall-clock budget of 3 ms.

While the block is running, separate stop requests can park the CPU group and the PCI group. A tristate control bit releases every output driver. There are six groups, numbered 0 to 5: CPU, PCI, SDRAM, AGP, REF and 48 MHz. The slow REF and 48 MHz groups may hold off the shutdown for many cycles until they reach their low phase.

Top module: `pdseq_ctrl`

## Requirements
- R1: The power-down request passes through a two-stage synchronizer. If `pd_req_n` is low at a rising edge, the phase is still RUN after the next rising edge and becomes STOPPING at the rising edge after that (the third edge counted from the capture).
- R2: Bit g of `grp_en` changes only at a rising edge where `grp_low[g]` was 1. While the block is not in RUN, a group whose `grp_low` bit is 1 has its enable cleared at the next edge.
- R3: `vco_en` drops only after every bit of `grp_en` is 0. The phase VCO_OFF lasts exactly one cycle, with `xtal_en` still 1. In XTAL_OFF, `xtal_en` is 0, and `vco_en` is never 1 while `xtal_en` is 0.
- R4: A group held in its high phase (`grp_low` bit 0) keeps its enable at 1 and holds the block in STOPPING, with the VCO on, for as long as that lasts. The sequence continues once that group reaches its low phase.
- R5: In RUN, `cpu_stop` parks group 0 and `pci_stop` parks group 1, and the other groups are unaffected. Outside RUN, both stop inputs have no effect, and no enable rises.
- R6: After the release is synchronized, the phase is WAKING for exactly XTAL_WAIT+VCO_WAIT cycles. `xtal_en` is 1 throughout, and `vco_en` is 0 for the first XTAL_WAIT of those cycles. The total must be less than 3 ms at CLK_KHZ.
- R7: After the return to RUN, each group's enable rises only at an edge where its low-phase flag is set.
- R8: `grp_oe` is the inverse of `tristate_all` in every phase.
- R9: `phase` encodes RUN=0, STOPPING=1, VCO_OFF=2, XTAL_OFF=3, WAKING=4. After reset the phase is RUN, all enables are 1, and `vco_en`=`xtal_en`=1.
- R10: If the request is released while the block is in STOPPING, the block returns to RUN without turning off the VCO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| rst_n | input | 1 | Active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| grp_low | input | 6 | Per-group flag, 1 while that group's clock is in its low phase |
| cpu_stop | input | 1 | Park the CPU group while running |
| pci_stop | input | 1 | Park the PCI group while running |
| tristate_all | input | 1 | Register bit that releases all output drivers |
| grp_en | output | 6 | Per-group clock enable |
| grp_oe | output | 1 | Output driver enable |
| vco_en | output | 1 | VCO enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| phase | output | 3 | Current sequence phase |

## Verification
The assertions check on every cycle that:
- each enable moves only in its group's low phase;
- the VCO is never off while any group is enabled;
- the crystal never runs without the VCO's order being respected;
- no enable rises outside RUN;
- the synchronizer delay precedes every shutdown;
- the restart stays inside its wall-clock budget.

Only the bench scenarios show the exact latencies. These are the three-edge request delay, the one-cycle VCO_OFF phase and the count of cycles in WAKING. The scenarios also show the effect of the stop inputs and of the tristate bit, a slow group holding off the shutdown, and an early release returning the block to RUN.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  localparam int GRP_N   = 6;
  localparam int GRP_CPU = 0;
  localparam int GRP_PCI = 1;

  typedef enum logic [2:0] {
    PH_RUN      = 3'd0,
    PH_STOPPING = 3'd1,
    PH_VCO_OFF  = 3'd2,
    PH_XTAL_OFF = 3'd3,
    PH_WAKING   = 3'd4
  } phase_t;

  // Target enable per group: all on in RUN except groups parked by a stop input.
  function automatic logic [GRP_N-1:0] want_mask(input logic running,
                                                 input logic cpu_stop,
                                                 input logic pci_stop);
    logic [GRP_N-1:0] m;
    m = running ? {GRP_N{1'b1}} : '0;
    if (cpu_stop) m[GRP_CPU] = 1'b0;
    if (pci_stop) m[GRP_PCI] = 1'b0;
    return m;
  endfunction

  // Number of cycles spent in WAKING.
  function automatic int wake_cycles(input int xtal_wait, input int vco_wait);
    return xtal_wait + vco_wait;
  endfunction

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pdseq_gate.sv
module pdseq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic low_phase,
  output logic en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en <= 1'b1;
    else if (low_phase) en <= want;
  end

  // R2 / R7: enable moves only while the group clock is low
  a_r2_move_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en) |-> $past(low_phase));
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
#(
  parameter int XTAL_WAIT     = 20,
  parameter int VCO_WAIT      = 12,
  parameter int CLK_KHZ       = 250000,
  parameter int WAKE_LIMIT_US = 3000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pd_act,
  input  logic   all_parked,
  output phase_t phase,
  output logic   vco_en,
  output logic   xtal_en
);
  localparam int TOTAL      = wake_cycles(XTAL_WAIT, VCO_WAIT);
  localparam int CW         = $clog2(TOTAL + 1);
  localparam int WAKE_LIMIT = CLK_KHZ / 1000 * WAKE_LIMIT_US;
  localparam int AW         = $clog2(WAKE_LIMIT + 1);
  localparam logic [CW-1:0] XW   = CW'(XTAL_WAIT);
  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_RUN:      if (pd_act) ph_d = PH_STOPPING;
      PH_STOPPING: if (!pd_act) ph_d = PH_RUN;
                   else if (all_parked) ph_d = PH_VCO_OFF;
      PH_VCO_OFF:  ph_d = PH_XTAL_OFF;
      PH_XTAL_OFF: if (!pd_act) ph_d = PH_WAKING;
      PH_WAKING:   if (cnt_q == LAST) ph_d = PH_RUN;
      default:     ph_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_RUN;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= (ph_q == PH_WAKING && ph_d == PH_WAKING) ? cnt_q + 1'b1 : '0;
    end
  end

  assign phase   = ph_q;
  assign xtal_en = (ph_q != PH_XTAL_OFF);
  assign vco_en  = !(ph_q == PH_VCO_OFF || ph_q == PH_XTAL_OFF ||
                     (ph_q == PH_WAKING && cnt_q < XW));

  // Wake-age counter for the wall-clock budget check (R6)
  logic [AW-1:0] wake_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wake_age <= '0;
    else if (ph_q != PH_WAKING) wake_age <= '0;
    else if (wake_age != '1)    wake_age <= wake_age + 1'b1;
  end

  initial a_r6_budget: assert (TOTAL > 0 && TOTAL < WAKE_LIMIT);

  a_r6_wake_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wake_age < AW'(WAKE_LIMIT));

  a_r3_parked_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_VCO_OFF) |-> all_parked);

  a_r3_xtal_order: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_en |-> !vco_en);

  a_r3_vco_off_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_VCO_OFF) |=> (ph_q == PH_XTAL_OFF));
endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
  import pdseq_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int XTAL_WAIT     = 20,
  parameter int VCO_WAIT      = 12,
  parameter int CLK_KHZ       = 250000,
  parameter int WAKE_LIMIT_US = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req_n,
  input  logic [GRP_N-1:0] grp_low,
  input  logic             cpu_stop,
  input  logic             pci_stop,
  input  logic             tristate_all,
  output logic [GRP_N-1:0] grp_en,
  output logic             grp_oe,
  output logic             vco_en,
  output logic             xtal_en,
  output logic [2:0]       phase
);
  logic             pd_act;
  logic             all_parked;
  logic [GRP_N-1:0] want;
  phase_t           ph;

  pdseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(!pd_req_n), .sync_out(pd_act)
  );

  assign want = want_mask(ph == PH_RUN, cpu_stop, pci_stop);

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    pdseq_gate u_gate (
      .clk(clk), .rst_n(rst_n), .want(want[g]),
      .low_phase(grp_low[g]), .en(grp_en[g])
    );
  end

  assign all_parked = (grp_en == '0);

  pdseq_fsm #(
    .XTAL_WAIT(XTAL_WAIT), .VCO_WAIT(VCO_WAIT),
    .CLK_KHZ(CLK_KHZ), .WAKE_LIMIT_US(WAKE_LIMIT_US)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_act(pd_act), .all_parked(all_parked),
    .phase(ph), .vco_en(vco_en), .xtal_en(xtal_en)
  );

  assign phase  = ph;
  assign grp_oe = !tristate_all;

  // R1: shutdown begins only after the request crossed the synchronizer
  a_r1_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_STOPPING && $past(ph) == PH_RUN) |-> !$past(pd_req_n, SYNC_STAGES));

  // R5: no enable rises outside RUN, whatever the stop inputs do
  a_r5_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_RUN) |=> ((grp_en & ~$past(grp_en)) == '0));
endmodule

// File: tb/pdseq_ctrl_bench.sv
module pdseq_ctrl_bench;
  localparam int XW = 20;
  localparam int VW = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_req_n = 1'b1;
  logic [5:0] grp_low = 6'h3F;
  logic       cpu_stop = 1'b0;
  logic       pci_stop = 1'b0;
  logic       tristate_all = 1'b0;
  logic [5:0] grp_en;
  logic       grp_oe, vco_en, xtal_en;
  logic [2:0] phase;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pdseq_ctrl u_pdseq_ctrl (
    .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .grp_low(grp_low),
    .cpu_stop(cpu_stop), .pci_stop(pci_stop), .tristate_all(tristate_all),
    .grp_en(grp_en), .grp_oe(grp_oe), .vco_en(vco_en), .xtal_en(xtal_en),
    .phase(phase)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // Vector table: {cpu_stop, pci_stop, tristate, expected grp_en, expected oe}
  typedef struct packed {
    logic       cs;
    logic       ps;
    logic       tri_s;
    logic [5:0] en;
    logic       oe;
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{1'b0, 1'b0, 1'b0, 6'h3F, 1'b1},
    '{1'b1, 1'b0, 1'b0, 6'h3E, 1'b1},
    '{1'b0, 1'b1, 1'b0, 6'h3D, 1'b1},
    '{1'b1, 1'b1, 1'b1, 6'h3C, 1'b0},
    '{1'b0, 1'b0, 1'b1, 6'h3F, 1'b0}
  };

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic go_down();
    pd_req_n = 1'b0;
    cyc(5);
  endtask

  task automatic wake_and_measure(output int wc, output int v0);
    wc = 0; v0 = 0;
    pd_req_n = 1'b1;
    cyc(3);
    while (phase == 3'd4 && wc < 1000) begin
      chk_eq("R6 xtal on in waking", xtal_en, 1);
      if (!vco_en) v0++;
      wc++;
      cyc(1);
    end
  endtask

  initial begin
    int wc, v0;
    cyc(3);
    // R9 reset state
    chk_eq("R9 reset phase", phase, 0);
    chk_eq("R9 reset en", grp_en, 6'h3F);
    chk_eq("R9 reset vco", vco_en, 1);
    chk_eq("R9 reset xtal", xtal_en, 1);
    rst_n = 1'b1;
    cyc(2);

    // R5 / R8 table walk
    foreach (VECS[i]) begin
      cpu_stop = VECS[i].cs; pci_stop = VECS[i].ps; tristate_all = VECS[i].tri_s;
      cyc(2);
      chk_eq("R5 run stop mask", grp_en, VECS[i].en);
      chk_eq("R8 tristate oe", grp_oe, VECS[i].oe);
    end
    cpu_stop = 0; pci_stop = 0; tristate_all = 0;
    cyc(2);

    // R1 synchronizer latency, R3 ordering
    pd_req_n = 1'b0;
    cyc(2);
    chk_eq("R1 still run after two edges", phase, 0);
    cyc(1);
    chk_eq("R1 stopping on third edge", phase, 1);
    cyc(1);
    chk_eq("R2 all parked", grp_en, 0);
    chk_eq("R3 vco still on while parking", vco_en, 1);
    cyc(1);
    chk_eq("R3 vco_off phase", phase, 2);
    chk_eq("R3 vco off", vco_en, 0);
    chk_eq("R3 xtal still on", xtal_en, 1);
    cyc(1);
    chk_eq("R3 xtal_off phase", phase, 3);
    chk_eq("R3 xtal off", xtal_en, 0);

    // R5 stops ignored while down, R8 tristate in any phase
    cpu_stop = 1; pci_stop = 1; tristate_all = 1;
    cyc(3);
    chk_eq("R5 phase unchanged", phase, 3);
    chk_eq("R5 enables held low", grp_en, 0);
    chk_eq("R8 oe low while down", grp_oe, 0);
    cpu_stop = 0; pci_stop = 0; tristate_all = 0;

    // R6 restart timing, R7 enables on low phase
    grp_low = 6'h00;
    wake_and_measure(wc, v0);
    chk_eq("R6 waking length", wc, XW + VW);
    chk_eq("R6 vco delayed", v0, XW);
    chk_eq("R6 back to run", phase, 0);
    cyc(3);
    chk_eq("R7 no enable in high phase", grp_en, 0);
    grp_low = 6'h05;
    cyc(1);
    chk_eq("R7 low groups enable", grp_en, 6'h05);
    grp_low = 6'h3F;
    cyc(1);
    chk_eq("R7 all enabled", grp_en, 6'h3F);

    // R4 slow REF group holds off shutdown
    grp_low = 6'h2F;
    pd_req_n = 1'b0;
    cyc(10);
    chk_eq("R4 held in stopping", phase, 1);
    chk_eq("R4 ref still on", grp_en, 6'h10);
    chk_eq("R4 vco on", vco_en, 1);
    grp_low = 6'h3F;
    cyc(1);
    chk_eq("R4 ref parked", grp_en, 0);
    cyc(1);
    chk_eq("R4 sequence continues", phase, 2);
    cyc(1);
    wake_and_measure(wc, v0);
    chk_eq("R6 second wake length", wc, XW + VW);
    cyc(2);

    // R10 release during STOPPING
    grp_low = 6'h1F;
    pd_req_n = 1'b0;
    cyc(6);
    chk_eq("R10 in stopping", phase, 1);
    pd_req_n = 1'b1;
    cyc(3);
    chk_eq("R10 back to run", phase, 0);
    chk_eq("R10 vco stayed on", vco_en, 1);
    grp_low = 6'h3F;
    cyc(2);
    chk_eq("R10 enables restored", grp_en, 6'h3F);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule